// File: doc/BRIEF.md
# Integer Execute Stage

This block is the integer execute stage of a load/store processor pipeline with 32-bit instructions. Each cycle it takes an instruction word and the two register values the read stage fetched for it (`src_a_i` for the rs field, `src_b_i` for the rt field). It decodes the register-register and register-immediate arithmetic, logic and shift operations, computes the result, and selects the destination register number. It then registers everything, so every output shows the instruction that was presented on the previous clock edge.

Add and subtract, trapping or not, go through one shared adder. That adder also reports the unsigned carry-out and the signed overflow. A trapping form that overflows raises the trap output and holds the register write back. Destination register 0, encodings that are not recognised, and reserved fields that are not zero all keep the write-enable low.

Top module: `int_exec_stage`

## Requirements
- R1: Outputs are registered: an instruction on the inputs at one rising edge is reflected on the outputs right after that edge. The destination is instr[15:11] when opcode instr[31:26] is 0, and instr[20:16] for the immediate opcodes.
- R2: addu (op 0, funct 0x21), subu (funct 0x23) and addiu (op 0x09) give the wrapped 32-bit sum or difference and never raise the trap, even when the signed result overflows.
- R3: add (funct 0x20), sub (funct 0x22) and addi (op 0x08) raise `ovf_trap_o` and drive `wr_en_o` low on signed overflow; otherwise they behave like the non-trapping forms.
- R4: For the six add/subtract operations, `carry_o` is the carry-out of A + B, or of A + ~B + 1 for subtraction, and `sovf_o` is signed overflow. Each can be set alone or both together. Both are 0 for every other operation.
- R5: funct 0x24, 0x25, 0x26 and 0x27 give the bitwise AND, OR, XOR and NOR of the two operands.
- R6: addi and addiu sign-extend the 16-bit immediate instr[15:0]. andi (op 0x0c), ori (0x0d) and xori (0x0e) zero-extend it.
- R7: funct 0 (left logical), 2 (right logical) and 3 (right arithmetic) shift the rt operand by the sa field instr[10:6]. The arithmetic form fills with the sign bit; the others fill with zero.
- R8: funct 4, 6 and 7 are the same three shifts, but the amount comes only from the low 5 bits of the rs operand.
- R9: Opcode 0x0f places the immediate in result bits [31:16] and zeros bits [15:0]. The rs operand value has no effect.
- R10: A destination number of 0 forces `wr_en_o` low, while the result is still produced.
- R11: An unrecognised opcode or funct, a non-zero sa field on a non-constant-shift register operation, or a non-zero rs field on a constant shift or upper-immediate load sets `illegal_o`. In that case write-enable, trap, carry and overflow are all 0.
- R12: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 32 | Value of the register named by the rs field |
| src_b_i | input | 32 | Value of the register named by the rt field |
| result_o | output | 32 | Computed result |
| dest_o | output | 5 | Destination register number |
| wr_en_o | output | 1 | Register write-enable |
| ovf_trap_o | output | 1 | Arithmetic overflow exception |
| carry_o | output | 1 | Unsigned carry-out of the adder |
| sovf_o | output | 1 | Signed overflow of the adder |
| illegal_o | output | 1 | Illegal instruction |

## Verification
The hardest cases to reach are the ones that separate the unsigned carry from the signed overflow. Each of them needs operands chosen at the exact edge of one range but not the other. The bench drives three additions that set carry alone, overflow alone and both together, and subtractions on both sides of a borrow. It then shows that the same overflowing operands trap on the trapping form but write on the non-trapping one. Sign handling of the immediates and of the variable shift amount also needs particular values: an all-ones immediate, and rs operands whose upper bits are set while the low five bits are small.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int INSN_W = 32;
    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int REG_W  = 5;
    localparam int SA_W   = 5;
    localparam int IMM_W  = 16;

    localparam logic [OP_W-1:0] OP_REG   = 6'h00;
    localparam logic [OP_W-1:0] OP_ADDI  = 6'h08;
    localparam logic [OP_W-1:0] OP_ADDIU = 6'h09;
    localparam logic [OP_W-1:0] OP_ANDI  = 6'h0c;
    localparam logic [OP_W-1:0] OP_ORI   = 6'h0d;
    localparam logic [OP_W-1:0] OP_XORI  = 6'h0e;
    localparam logic [OP_W-1:0] OP_LUI   = 6'h0f;

    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
    localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
    localparam logic [FN_W-1:0] FN_SRAV = 6'h07;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
    localparam logic [FN_W-1:0] FN_NOR  = 6'h27;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_SHL, K_SHR, K_SHRA, K_LUI
    } op_kind_e;

    typedef enum logic [1:0] {
        B_REG, B_SEXT, B_ZEXT
    } bsel_e;

    typedef struct packed {
        op_kind_e kind;
        bsel_e    bsel;
        logic     var_amt;
        logic     traps;
        logic     dest_rt;
        logic     legal;
    } ctl_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [FN_W-1:0] fn_i,
    input  logic            rs_zero_i,
    input  logic            sa_zero_i,
    output ctl_t            ctl_o
);

    always_comb begin
        ctl_o         = '0;
        ctl_o.kind    = K_NONE;
        ctl_o.bsel    = B_REG;
        unique case (op_i)
            OP_REG: begin
                ctl_o.legal = sa_zero_i;
                unique case (fn_i)
                    FN_ADD:  begin ctl_o.kind = K_ADD; ctl_o.traps = 1'b1; end
                    FN_ADDU: ctl_o.kind = K_ADD;
                    FN_SUB:  begin ctl_o.kind = K_SUB; ctl_o.traps = 1'b1; end
                    FN_SUBU: ctl_o.kind = K_SUB;
                    FN_AND:  ctl_o.kind = K_AND;
                    FN_OR:   ctl_o.kind = K_OR;
                    FN_XOR:  ctl_o.kind = K_XOR;
                    FN_NOR:  ctl_o.kind = K_NOR;
                    FN_SLL:  begin ctl_o.kind = K_SHL;  ctl_o.legal = rs_zero_i; end
                    FN_SRL:  begin ctl_o.kind = K_SHR;  ctl_o.legal = rs_zero_i; end
                    FN_SRA:  begin ctl_o.kind = K_SHRA; ctl_o.legal = rs_zero_i; end
                    FN_SLLV: begin ctl_o.kind = K_SHL;  ctl_o.var_amt = 1'b1; end
                    FN_SRLV: begin ctl_o.kind = K_SHR;  ctl_o.var_amt = 1'b1; end
                    FN_SRAV: begin ctl_o.kind = K_SHRA; ctl_o.var_amt = 1'b1; end
                    default: ctl_o.legal = 1'b0;
                endcase
            end
            OP_ADDI: begin
                ctl_o = '{kind: K_ADD, bsel: B_SEXT, var_amt: 1'b0, traps: 1'b1,
                          dest_rt: 1'b1, legal: 1'b1};
            end
            OP_ADDIU: begin
                ctl_o = '{kind: K_ADD, bsel: B_SEXT, var_amt: 1'b0, traps: 1'b0,
                          dest_rt: 1'b1, legal: 1'b1};
            end
            OP_ANDI: begin
                ctl_o = '{kind: K_AND, bsel: B_ZEXT, var_amt: 1'b0, traps: 1'b0,
                          dest_rt: 1'b1, legal: 1'b1};
            end
            OP_ORI: begin
                ctl_o = '{kind: K_OR, bsel: B_ZEXT, var_amt: 1'b0, traps: 1'b0,
                          dest_rt: 1'b1, legal: 1'b1};
            end
            OP_XORI: begin
                ctl_o = '{kind: K_XOR, bsel: B_ZEXT, var_amt: 1'b0, traps: 1'b0,
                          dest_rt: 1'b1, legal: 1'b1};
            end
            OP_LUI: begin
                ctl_o = '{kind: K_LUI, bsel: B_ZEXT, var_amt: 1'b0, traps: 1'b0,
                          dest_rt: 1'b1, legal: rs_zero_i};
            end
            default: ctl_o.legal = 1'b0;
        endcase
        if (!ctl_o.legal) begin
            ctl_o.kind  = K_NONE;
            ctl_o.traps = 1'b0;
        end
    end

endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         sovf_o
);

    logic [W-1:0] bx;
    logic [W-1:0] low;
    logic [1:0]   top;

    always_comb begin
        bx  = sub_i ? ~b_i : b_i;
        // low part: bits below the MSB, with the MSB position catching their carry
        low = {1'b0, a_i[W-2:0]} + {1'b0, bx[W-2:0]} + W'(sub_i);
        top = {1'b0, a_i[W-1]} + {1'b0, bx[W-1]} + {1'b0, low[W-1]};
        sum_o   = {top[0], low[W-2:0]};
        carry_o = top[1];
        sovf_o  = low[W-1] ^ top[1];
    end

endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
    parameter int W = 32
) (
    input  logic [W-1:0]         val_i,
    input  logic [$clog2(W)-1:0] amt_i,
    input  logic                 left_i,
    input  logic                 arith_i,
    output logic [W-1:0]         out_o
);

    localparam int STAGES = $clog2(W);

    logic [W-1:0] lst [STAGES+1];
    logic [W-1:0] rst [STAGES+1];
    logic         fill;

    assign fill   = arith_i & val_i[W-1];
    assign lst[0] = val_i;
    assign rst[0] = val_i;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign lst[i+1] = amt_i[i] ? {lst[i][W-1-STEP:0], {STEP{1'b0}}} : lst[i];
        assign rst[i+1] = amt_i[i] ? {{STEP{fill}}, rst[i][W-1:STEP]} : rst[i];
    end

    assign out_o = left_i ? lst[STAGES] : rst[STAGES];

endmodule

// File: rtl/int_exec_stage.sv
module int_exec_stage
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      instr_i,
    input  logic [XLEN-1:0]  src_a_i,
    input  logic [XLEN-1:0]  src_b_i,
    output logic [XLEN-1:0]  result_o,
    output logic [REG_W-1:0] dest_o,
    output logic             wr_en_o,
    output logic             ovf_trap_o,
    output logic             carry_o,
    output logic             sovf_o,
    output logic             illegal_o
);

    localparam int SHW = $clog2(XLEN);

    typedef struct packed {
        logic [XLEN-1:0]  result;
        logic [REG_W-1:0] dest;
        logic             wen;
        logic             trap;
        logic             carry;
        logic             sovf;
        logic             illegal;
    } exo_t;

    logic [OP_W-1:0]  op_f;
    logic [REG_W-1:0] rs_f, rt_f, rd_f;
    logic [SA_W-1:0]  sa_f;
    logic [FN_W-1:0]  fn_f;
    logic [IMM_W-1:0] imm_f;

    assign op_f  = instr_i[31:26];
    assign rs_f  = instr_i[25:21];
    assign rt_f  = instr_i[20:16];
    assign rd_f  = instr_i[15:11];
    assign sa_f  = instr_i[10:6];
    assign fn_f  = instr_i[5:0];
    assign imm_f = instr_i[15:0];

    ctl_t ctl;

    exu_decode u_dec (
        .op_i      (op_f),
        .fn_i      (fn_f),
        .rs_zero_i (rs_f == '0),
        .sa_zero_i (sa_f == '0),
        .ctl_o     (ctl)
    );

    logic [XLEN-1:0] b_opnd;
    always_comb begin
        unique case (ctl.bsel)
            B_SEXT:  b_opnd = {{(XLEN-IMM_W){imm_f[IMM_W-1]}}, imm_f};
            B_ZEXT:  b_opnd = {{(XLEN-IMM_W){1'b0}}, imm_f};
            default: b_opnd = src_b_i;
        endcase
    end

    logic [XLEN-1:0] sum;
    logic            add_c, add_v;

    exu_addsub #(.W(XLEN)) u_add (
        .a_i     (src_a_i),
        .b_i     (b_opnd),
        .sub_i   (ctl.kind == K_SUB),
        .sum_o   (sum),
        .carry_o (add_c),
        .sovf_o  (add_v)
    );

    logic [SHW-1:0]  amt;
    logic [XLEN-1:0] shifted;

    assign amt = ctl.var_amt ? src_a_i[SHW-1:0] : SHW'(sa_f);

    exu_shifter #(.W(XLEN)) u_shf (
        .val_i   (src_b_i),
        .amt_i   (amt),
        .left_i  (ctl.kind == K_SHL),
        .arith_i (ctl.kind == K_SHRA),
        .out_o   (shifted)
    );

    exo_t out_d, out_q;
    logic arith;

    always_comb begin
        out_d = '0;
        arith = (ctl.kind == K_ADD) || (ctl.kind == K_SUB);
        unique case (ctl.kind)
            K_ADD, K_SUB:        out_d.result = sum;
            K_AND:               out_d.result = src_a_i & b_opnd;
            K_OR:                out_d.result = src_a_i | b_opnd;
            K_XOR:               out_d.result = src_a_i ^ b_opnd;
            K_NOR:               out_d.result = ~(src_a_i | b_opnd);
            K_SHL, K_SHR, K_SHRA: out_d.result = shifted;
            K_LUI:               out_d.result = {imm_f, {(XLEN-IMM_W){1'b0}}};
            default:             out_d.result = '0;
        endcase
        out_d.illegal = !ctl.legal;
        if (ctl.legal) begin
            out_d.dest  = ctl.dest_rt ? rt_f : rd_f;
            out_d.carry = arith & add_c;
            out_d.sovf  = arith & add_v;
            out_d.trap  = arith & ctl.traps & add_v;
            out_d.wen   = (out_d.dest != '0) && !out_d.trap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o   = out_q.result;
    assign dest_o     = out_q.dest;
    assign wr_en_o    = out_q.wen;
    assign ovf_trap_o = out_q.trap;
    assign carry_o    = out_q.carry;
    assign sovf_o     = out_q.sovf;
    assign illegal_o  = out_q.illegal;

    // marks cycles whose outputs come from inputs sampled after reset
    logic live_q;
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    a_r2_addu_wraps: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        ($past(instr_i[31:26]) == 6'h00 && $past(instr_i[10:0]) == 11'h021)
        |-> (result_o == XLEN'($past(src_a_i) + $past(src_b_i)) && !ovf_trap_o));

    a_r3_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap_o |-> (!wr_en_o && sovf_o && !illegal_o));

    a_r9_lui_low_zero: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        ($past(instr_i[31:21]) == 11'h1e0)
        |-> (result_o[IMM_W-1:0] == '0 && result_o[XLEN-1:XLEN-IMM_W] == $past(instr_i[15:0])));

    a_r10_no_write_r0: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (dest_o != '0));

    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wr_en_o && !ovf_trap_o && !carry_o && !sovf_o));

    a_r1_imm_dest_rt: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        ($past(instr_i[31:26]) == 6'h09) |-> (dest_o == $past(instr_i[20:16])));

endmodule

// File: tb/int_exec_stage_tb.sv
module int_exec_stage_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [31:0] result_o;
    logic [4:0]  dest_o;
    logic        wr_en_o, ovf_trap_o, carry_o, sovf_o, illegal_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    int_exec_stage u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .result_o(result_o), .dest_o(dest_o),
        .wr_en_o(wr_en_o), .ovf_trap_o(ovf_trap_o), .carry_o(carry_o),
        .sovf_o(sovf_o), .illegal_o(illegal_o)
    );

    function automatic logic [31:0] rtyp(input logic [4:0] rs, rt, rd, sa, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, sa, fn};
    endfunction

    function automatic logic [31:0] ityp(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // drive on a falling edge, let one rising edge pass, sample on the next falling edge
    task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr_i = ins; src_a_i = a; src_b_i = b;
        @(negedge clk);
    endtask

    task automatic flags(input string tag, input logic w, t, c, v, il);
        chk({tag, " wr_en"},   32'(wr_en_o),    32'(w));
        chk({tag, " trap"},    32'(ovf_trap_o), 32'(t));
        chk({tag, " carry"},   32'(carry_o),    32'(c));
        chk({tag, " sovf"},    32'(sovf_o),     32'(v));
        chk({tag, " illegal"}, 32'(illegal_o),  32'(il));
    endtask

    task automatic t_reset();
        instr_i = rtyp(5'd1, 5'd2, 5'd3, 5'd0, 6'h21); src_a_i = 32'd5; src_b_i = 32'd6;
        repeat (3) @(negedge clk);
        chk("R12 result", result_o, 32'h0);
        chk("R12 dest", 32'(dest_o), 32'h0);
        flags("R12", 0, 0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_carry_ovf();
        issue(rtyp(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), 32'hFFFF_FFFF, 32'h1);
        chk("R4 carry-only sum", result_o, 32'h0);
        chk("R1 dest rd", 32'(dest_o), 32'd3);
        flags("R4 carry-only", 1, 0, 1, 0, 0);
        issue(rtyp(5'd1, 5'd2, 5'd4, 5'd0, 6'h21), 32'h7FFF_FFFF, 32'h1);
        chk("R2 addu wraps", result_o, 32'h8000_0000);
        flags("R2/R4 ovf-only addu", 1, 0, 0, 1, 0);
        issue(rtyp(5'd1, 5'd2, 5'd4, 5'd0, 6'h21), 32'h8000_0000, 32'h8000_0000);
        chk("R4 both sum", result_o, 32'h0);
        flags("R4 both", 1, 0, 1, 1, 0);
    endtask

    task automatic t_trap();
        issue(rtyp(5'd1, 5'd2, 5'd5, 5'd0, 6'h20), 32'h7FFF_FFFF, 32'h1);
        flags("R3 add overflow", 0, 1, 0, 1, 0);
        issue(rtyp(5'd1, 5'd2, 5'd5, 5'd0, 6'h20), 32'd40, 32'd2);
        chk("R3 add normal", result_o, 32'd42);
        flags("R3 add normal", 1, 0, 0, 0, 0);
        issue(rtyp(5'd1, 5'd2, 5'd6, 5'd0, 6'h22), 32'd5, 32'd3);
        chk("R3 sub", result_o, 32'd2);
        flags("R4 sub no borrow", 1, 0, 1, 0, 0);
        issue(rtyp(5'd1, 5'd2, 5'd6, 5'd0, 6'h23), 32'd3, 32'd5);
        chk("R2 subu", result_o, 32'hFFFF_FFFE);
        flags("R4 subu borrow", 1, 0, 0, 0, 0);
        issue(rtyp(5'd1, 5'd2, 5'd6, 5'd0, 6'h22), 32'h8000_0000, 32'h1);
        flags("R3 sub overflow", 0, 1, 1, 1, 0);
        issue(rtyp(5'd1, 5'd2, 5'd6, 5'd0, 6'h23), 32'h8000_0000, 32'h1);
        chk("R2 subu overflow value", result_o, 32'h7FFF_FFFF);
        flags("R2 subu no trap", 1, 0, 1, 1, 0);
        issue(ityp(6'h08, 5'd1, 5'd7, 16'h0001), 32'h7FFF_FFFF, 32'h0);
        flags("R3 addi overflow", 0, 1, 0, 1, 0);
    endtask

    task automatic t_logic();
        issue(rtyp(5'd1, 5'd2, 5'd8, 5'd0, 6'h24), 32'hABCD_1234, 32'hFFFF_0000);
        chk("R5 and", result_o, 32'hABCD_0000);
        flags("R5 and", 1, 0, 0, 0, 0);
        issue(rtyp(5'd1, 5'd2, 5'd8, 5'd0, 6'h25), 32'hABCD_1234, 32'hFFFF_0000);
        chk("R5 or", result_o, 32'hFFFF_1234);
        issue(rtyp(5'd1, 5'd2, 5'd8, 5'd0, 6'h26), 32'hABCD_1234, 32'hFFFF_0000);
        chk("R5 xor", result_o, 32'h5432_1234);
        issue(rtyp(5'd1, 5'd2, 5'd8, 5'd0, 6'h27), 32'hABCD_1234, 32'hFFFF_0000);
        chk("R5 nor", result_o, 32'h0000_EDCB);
    endtask

    task automatic t_imm();
        issue(ityp(6'h09, 5'd1, 5'd9, 16'hFFFF), 32'd10, 32'hDEAD_BEEF);
        chk("R6 addiu sext", result_o, 32'd9);
        chk("R1 dest rt", 32'(dest_o), 32'd9);
        flags("R2 addiu", 1, 0, 1, 0, 0);
        issue(ityp(6'h0c, 5'd1, 5'd10, 16'h8001), 32'hFFFF_FFFF, 32'h0);
        chk("R6 andi zext", result_o, 32'h0000_8001);
        issue(ityp(6'h0d, 5'd1, 5'd10, 16'h8000), 32'h0, 32'hFFFF_FFFF);
        chk("R6 ori zext", result_o, 32'h0000_8000);
        issue(ityp(6'h0e, 5'd1, 5'd10, 16'hFFFF), 32'hFFFF_0000, 32'h0);
        chk("R6 xori zext", result_o, 32'hFFFF_FFFF);
        issue(ityp(6'h0f, 5'd0, 5'd11, 16'hAC51), 32'h0000_1234, 32'h5555_5555);
        chk("R9 lui", result_o, 32'hAC51_0000);
        chk("R9 lui dest", 32'(dest_o), 32'd11);
    endtask

    task automatic t_shift();
        issue(rtyp(5'd0, 5'd2, 5'd12, 5'd8, 6'h00), 32'hFFFF_FFFF, 32'hABCD_1234);
        chk("R7 sll 8", result_o, 32'hCD12_3400);
        issue(rtyp(5'd0, 5'd2, 5'd12, 5'd4, 6'h03), 32'h0, 32'hABCD_1234);
        chk("R7 sra 4", result_o, 32'hFABC_D123);
        issue(rtyp(5'd0, 5'd2, 5'd12, 5'd4, 6'h02), 32'h0, 32'hABCD_1234);
        chk("R7 srl 4", result_o, 32'h0ABC_D123);
        issue(rtyp(5'd0, 5'd2, 5'd12, 5'd31, 6'h03), 32'h0, 32'h4000_0000);
        chk("R7 sra positive 31", result_o, 32'h0);
        issue(rtyp(5'd3, 5'd2, 5'd12, 5'd0, 6'h06), 32'd16, 32'hABCD_1234);
        chk("R8 srlv 16", result_o, 32'h0000_ABCD);
        issue(rtyp(5'd3, 5'd2, 5'd12, 5'd0, 6'h07), 32'h0000_0024, 32'hABCD_1234);
        chk("R8 srav low5=4", result_o, 32'hFABC_D123);
        issue(rtyp(5'd3, 5'd2, 5'd12, 5'd0, 6'h04), 32'hFFFF_FFE1, 32'hABCD_1234);
        chk("R8 sllv low5=1", result_o, 32'h579A_2468);
        flags("R8 sllv", 1, 0, 0, 0, 0);
    endtask

    task automatic t_r0_illegal();
        issue(rtyp(5'd1, 5'd2, 5'd0, 5'd0, 6'h21), 32'd7, 32'd8);
        chk("R10 result kept", result_o, 32'd15);
        flags("R10 dest zero", 0, 0, 0, 0, 0);
        issue(ityp(6'h3f, 5'd1, 5'd2, 16'h1234), 32'hFFFF_FFFF, 32'h1);
        flags("R11 bad opcode", 0, 0, 0, 0, 1);
        issue(rtyp(5'd1, 5'd2, 5'd3, 5'd0, 6'h01), 32'hFFFF_FFFF, 32'h1);
        flags("R11 bad funct", 0, 0, 0, 0, 1);
        issue(rtyp(5'd3, 5'd2, 5'd12, 5'd4, 6'h00), 32'h0, 32'h1);
        flags("R11 sll rs nonzero", 0, 0, 0, 0, 1);
        issue(rtyp(5'd1, 5'd2, 5'd3, 5'd1, 6'h20), 32'h7FFF_FFFF, 32'h1);
        flags("R11 add sa nonzero", 0, 0, 0, 0, 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        t_reset();
        t_carry_ovf();
        t_trap();
        t_logic();
        t_imm();
        t_shift();
        t_r0_illegal();
        summary();
    end

endmodule